// File: doc/BRIEF.md
# Software Interrupt Request Controller

This block keeps seven software interrupt requests, each with its own enable, and decides on every cycle whether one of them should interrupt the processor. Software raises an interrupt by setting its request flag through a small register port. It clears the flag through the same port, normally just before the handler returns. The request numbered n carries the fixed priority n, so request 7 is the most urgent and request 1 the least.

A pending request counts only while its enable flag is also set. The most urgent of these eligible requests is compared with two other levels. The first is the execution priority the processor is running at. The second is the priority of the best hardware event interrupt waiting at the same moment. The request is raised only when it is strictly above both. When it is raised, the block presents the request number, its priority and the start of its four-byte vector slot.

The processor acknowledges with a strobe. The block answers that strobe with a one-cycle confirmation. The acknowledge does not change any request flag.

Top module: `swi_ctrl`

## Requirements
- R1: After reset both the request register and the enable register read as zero, irq is low and taken is low.
- R2: A write with reg_sel=0 loads the request register and a write with reg_sel=1 loads the enable register. Data bit n (n = 1..7) belongs to request n. The read port returns the register chosen by reg_sel.
- R3: Bit 0 of both registers always reads 0, whatever value is written to it.
- R4: A request can take part in arbitration only while both its request bit and its enable bit are 1.
- R5: Among the eligible requests, the one with the highest number wins.
- R6: The winner drives irq only when its priority is strictly greater than cur_prio. At equal priority irq stays low.
- R7: While evt_valid is 1, irq is raised only when the winner's priority is strictly greater than evt_prio, so the event interrupt wins a tie. While evt_valid is 0, evt_prio has no effect.
- R8: While irq is 1, irq_num is n, irq_prio is n and irq_vector is 0x0100 + 4*(n-1). While irq is 0, all three are 0.
- R9: An acknowledge leaves the request bit set, so irq stays high. The request clears only when software writes its bit to 0.
- R10: taken is high for exactly the cycle that follows a cycle in which ack and irq were both high. An ack while irq is low produces no taken.
- R11: A register write changes the stored value at the next clock edge. A read in the same cycle as the write returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 request, 1 enable |
| reg_wdata | input | 8 | Write data, bit n for request n |
| reg_rdata | output | 8 | Read data of the selected register |
| cur_prio | input | 4 | Current execution priority |
| evt_valid | input | 1 | An event interrupt is pending |
| evt_prio | input | 4 | Priority of the best pending event interrupt |
| ack | input | 1 | Interrupt acknowledge strobe |
| irq | output | 1 | Software interrupt request to the processor |
| irq_num | output | 3 | Number of the winning request |
| irq_prio | output | 4 | Fixed priority of the winning request |
| irq_vector | output | 16 | Vector slot address of the winning request |
| taken | output | 1 | One-cycle confirmation of an acknowledged request |

## Verification
The assertions assume that the register port, the two priority inputs and ack are driven to known values from reset onward. They also assume that these inputs change only away from the clock edge. The bench drives every input once, just after a rising edge, and holds it for the whole cycle, so none is ever undefined or changing at an edge. The persistence check on the request register assumes that only a register write may change it. The stimulus therefore uses ack and priority changes on their own, without a write, to show that irq stays up.

// File: rtl/swi_pkg.sv
package swi_pkg;
   // Defaults shared by the controller and its sub-blocks
   parameter int unsigned SWI_COUNT  = 7;
   parameter int unsigned PRIO_BITS  = 4;
   parameter int unsigned DATA_BITS  = 8;
   parameter int unsigned VEC_BITS   = 16;
   parameter int unsigned VEC_ORIGIN = 16'h0100;
   parameter int unsigned VEC_STEP   = 4;

   typedef enum logic {
      SEL_REQ = 1'b0,
      SEL_EN  = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/swi_regs.sv
module swi_regs
   import swi_pkg::*;
#(
   parameter int unsigned NUM_SWI = SWI_COUNT,
   parameter int unsigned DATA_W  = DATA_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [NUM_SWI:1]  req_o,
   output logic [NUM_SWI:1]  en_o
);
   logic [NUM_SWI:1] req_q;
   logic [NUM_SWI:1] en_q;

   // One request flop and one enable flop per software interrupt
   for (genvar g = 1; g <= NUM_SWI; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            req_q[g] <= 1'b0;
            en_q[g]  <= 1'b0;
         end else if (wr) begin
            if (sel == SEL_REQ) req_q[g] <= wdata[g];
            else                en_q[g]  <= wdata[g];
         end
      end
   end

   // Read mux: the reserved bit and unused upper bits stay zero
   always_comb begin
      rdata = '0;
      for (int i = 1; i <= NUM_SWI; i++) begin
         rdata[i] = (sel == SEL_EN) ? en_q[i] : req_q[i];
      end
   end

   assign req_o = req_q;
   assign en_o  = en_q;

   logic unused_wbits;
   if (DATA_W > NUM_SWI + 1) begin : g_wide
      assign unused_wbits = ^{wdata[0], wdata[DATA_W-1:NUM_SWI+1]};
   end else begin : g_exact
      assign unused_wbits = wdata[0];
   end

   // R9: without a write to the request register, the requests never change
   a_r9_req_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && sel == SEL_REQ) |=> $stable(req_q));

   // R2: a request-register write loads the written bits
   a_r2_req_load : assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == SEL_REQ) |=> (req_q == $past(wdata[NUM_SWI:1])));

   // R2: an enable-register write leaves the requests alone
   a_r2_en_only : assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == SEL_EN) |=> $stable(req_q));
endmodule

// File: rtl/swi_arbiter.sv
module swi_arbiter
   import swi_pkg::*;
#(
   parameter int unsigned NUM_SWI      = SWI_COUNT,
   parameter int unsigned PRIO_W       = PRIO_BITS,
   parameter bit          EVT_WINS_TIE = 1'b1,
   parameter int unsigned NUM_W        = $clog2(NUM_SWI + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_SWI:1]  pend,
   input  logic [PRIO_W-1:0] cur_prio,
   input  logic              evt_valid,
   input  logic [PRIO_W-1:0] evt_prio,
   output logic              win,
   output logic [NUM_W-1:0]  win_num
);
   logic [NUM_W-1:0]  best;
   logic              found;
   logic [PRIO_W-1:0] best_prio;
   logic              beats_cur;
   logic              beats_evt;

   // Fixed priority: the highest eligible index wins
   always_comb begin
      best  = '0;
      found = 1'b0;
      for (int i = 1; i <= NUM_SWI; i++) begin
         if (pend[i]) begin
            best  = NUM_W'(i);
            found = 1'b1;
         end
      end
   end

   assign best_prio = PRIO_W'(best);
   assign beats_cur = best_prio > cur_prio;

   // Tie rule against the pending event interrupt
   if (EVT_WINS_TIE) begin : g_evt_tie
      assign beats_evt = !evt_valid || (best_prio > evt_prio);
   end else begin : g_swi_tie
      assign beats_evt = !evt_valid || (best_prio >= evt_prio);
   end

   assign win     = found && beats_cur && beats_evt;
   assign win_num = win ? best : '0;

   // R6: a raised request is strictly above the execution level
   a_r6_above_cur : assert property (@(posedge clk) disable iff (!rst_n)
      win |-> (PRIO_W'(win_num) > cur_prio));

   // R7: a raised request outranks a pending event interrupt
   a_r7_above_evt : assert property (@(posedge clk) disable iff (!rst_n)
      (win && evt_valid && EVT_WINS_TIE) |-> (PRIO_W'(win_num) > evt_prio));

   // R4: the winner is among the eligible requests
   a_r4_eligible : assert property (@(posedge clk) disable iff (!rst_n)
      win |-> pend[win_num]);

   // R5: no eligible request above the winner
   a_r5_highest : assert property (@(posedge clk) disable iff (!rst_n)
      win |-> ((pend >> win_num) == '0));
endmodule

// File: rtl/swi_vector.sv
module swi_vector
   import swi_pkg::*;
#(
   parameter int unsigned NUM_W    = 3,
   parameter int unsigned VEC_W    = VEC_BITS,
   parameter int unsigned VEC_BASE = VEC_ORIGIN,
   parameter int unsigned VEC_STR  = VEC_STEP
) (
   input  logic             valid,
   input  logic [NUM_W-1:0] num,
   output logic [VEC_W-1:0] vector
);
   logic [NUM_W-1:0] slot;
   logic [VEC_W-1:0] offset;

   // Slot 0 belongs to request 1
   assign slot   = num - NUM_W'(1);
   assign offset = VEC_W'(VEC_STR) * {{(VEC_W-NUM_W){1'b0}}, slot};
   assign vector = valid ? (VEC_W'(VEC_BASE) + offset) : '0;
endmodule

// File: rtl/swi_ctrl.sv
module swi_ctrl
   import swi_pkg::*;
#(
   parameter int unsigned NUM_SWI      = SWI_COUNT,
   parameter int unsigned PRIO_W       = PRIO_BITS,
   parameter int unsigned DATA_W       = DATA_BITS,
   parameter int unsigned VEC_W        = VEC_BITS,
   parameter int unsigned VEC_BASE     = VEC_ORIGIN,
   parameter int unsigned VEC_STR      = VEC_STEP,
   parameter bit          EVT_WINS_TIE = 1'b1,
   parameter int unsigned NUM_W        = $clog2(NUM_SWI + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [PRIO_W-1:0] cur_prio,
   input  logic              evt_valid,
   input  logic [PRIO_W-1:0] evt_prio,
   input  logic              ack,
   output logic              irq,
   output logic [NUM_W-1:0]  irq_num,
   output logic [PRIO_W-1:0] irq_prio,
   output logic [VEC_W-1:0]  irq_vector,
   output logic              taken
);
   // Elaboration-time parameter checks
   if (NUM_SWI < 1 || NUM_SWI > (2**PRIO_W) - 1) begin : g_bad_count
      $error("swi_ctrl: NUM_SWI must be between 1 and 2**PRIO_W-1");
   end
   if (DATA_W < NUM_SWI + 1) begin : g_bad_data
      $error("swi_ctrl: DATA_W must hold the reserved bit and every request");
   end
   if (VEC_W < NUM_W) begin : g_bad_vec
      $error("swi_ctrl: VEC_W too narrow");
   end

   logic [NUM_SWI:1] req_bits;
   logic [NUM_SWI:1] en_bits;
   logic [NUM_SWI:1] pend;
   logic             win;
   logic [NUM_W-1:0] win_num;
   logic             taken_q;

   swi_regs #(
      .NUM_SWI (NUM_SWI),
      .DATA_W  (DATA_W)
   ) regs_i (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (reg_wr),
      .sel   (reg_sel),
      .wdata (reg_wdata),
      .rdata (reg_rdata),
      .req_o (req_bits),
      .en_o  (en_bits)
   );

   assign pend = req_bits & en_bits;

   swi_arbiter #(
      .NUM_SWI      (NUM_SWI),
      .PRIO_W       (PRIO_W),
      .EVT_WINS_TIE (EVT_WINS_TIE),
      .NUM_W        (NUM_W)
   ) arb_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pend      (pend),
      .cur_prio  (cur_prio),
      .evt_valid (evt_valid),
      .evt_prio  (evt_prio),
      .win       (win),
      .win_num   (win_num)
   );

   swi_vector #(
      .NUM_W    (NUM_W),
      .VEC_W    (VEC_W),
      .VEC_BASE (VEC_BASE),
      .VEC_STR  (VEC_STR)
   ) vec_i (
      .valid  (win),
      .num    (win_num),
      .vector (irq_vector)
   );

   assign irq      = win;
   assign irq_num  = win_num;
   assign irq_prio = PRIO_W'(win_num);

   // Acknowledge confirmation, one cycle after the accepted strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) taken_q <= 1'b0;
      else        taken_q <= ack & win;
   end
   assign taken = taken_q;

   // R10: taken only follows an ack
   a_r10_taken_src : assert property (@(posedge clk) disable iff (!rst_n)
      taken |-> $past(ack));

   // R10: an accepted ack always yields taken
   a_r10_taken_fire : assert property (@(posedge clk) disable iff (!rst_n)
      (ack && irq) |=> taken);

   // R8: outputs are quiet while no request is raised
   a_r8_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> (irq_num == '0 && irq_vector == '0));

   // R8: the vector lies inside the software vector window
   a_r8_vec_range : assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (irq_vector >= VEC_W'(VEC_BASE)));

   // R9: with nothing else changing, an ack does not drop the request
   a_r9_ack_keeps : assert property (@(posedge clk) disable iff (!rst_n)
      (ack && irq && !reg_wr) ##1 ($stable(cur_prio) && $stable(evt_valid)
         && $stable(evt_prio)) |-> irq);
endmodule

// File: tb/swi_ctrl_tb.sv
`timescale 1ns/1ps
module swi_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_sel = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [3:0]  cur_prio = '0;
   logic        evt_valid = 1'b0;
   logic [3:0]  evt_prio = '0;
   logic        ack = 1'b0;
   logic        irq;
   logic [2:0]  irq_num;
   logic [3:0]  irq_prio;
   logic [15:0] irq_vector;
   logic        taken;

   typedef struct {
      string       req;
      int          sig;
      logic [31:0] exp;
   } item_t;

   item_t exp_q[$];
   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   logic [7:0] sh_req = '0;
   logic [7:0] sh_en  = '0;

   always #5 clk = ~clk;

   swi_ctrl dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_sel    (reg_sel),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .cur_prio   (cur_prio),
      .evt_valid  (evt_valid),
      .evt_prio   (evt_prio),
      .ack        (ack),
      .irq        (irq),
      .irq_num    (irq_num),
      .irq_prio   (irq_prio),
      .irq_vector (irq_vector),
      .taken      (taken)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic push(string r, int s, logic [31:0] e);
      item_t it;
      it.req = r; it.sig = s; it.exp = e;
      exp_q.push_back(it);
   endtask

   // Independent reference model: the highest enabled request above both levels
   task automatic expect_out(string r);
      int cand = 0;
      bit hit;
      for (int n = 1; n <= 7; n++) if (sh_req[n] && sh_en[n]) cand = n;
      hit = (cand != 0) && (cand > cur_prio) && (!evt_valid || cand > evt_prio);
      push(r, 0, hit);
      push(r, 1, hit ? cand : 0);
      push(r, 2, hit ? cand : 0);
      push(r, 3, hit ? (32'h100 + 4 * (cand - 1)) : 0);
   endtask

   task automatic expect_rd(string r, bit sel);
      reg_sel = sel;
      push(r, 4, sel ? sh_en : sh_req);
   endtask

   task automatic wr(bit sel, logic [7:0] d);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      step();
      reg_wr = 1'b0;
      if (sel) sh_en = d & 8'hFE; else sh_req = d & 8'hFE;
   endtask

   // Monitor: compares every queued item in the middle of the cycle
   initial begin
      forever begin
         @(negedge clk);
         while (exp_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            string nm;
            it = exp_q.pop_front();
            case (it.sig)
               0: begin act = irq;        nm = "irq";        end
               1: begin act = irq_num;    nm = "irq_num";    end
               2: begin act = irq_prio;   nm = "irq_prio";   end
               3: begin act = irq_vector; nm = "irq_vector"; end
               4: begin act = reg_rdata;  nm = "reg_rdata";  end
               default: begin act = taken; nm = "taken";     end
            endcase
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s %s actual=%0h expected=%0h", it.req, nm, act, it.exp);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog all requirements actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();
      // R1: reset state
      expect_rd("R1", 0); push("R1", 5, 0); expect_out("R1"); step();
      expect_rd("R1", 1); step();

      // R4: enables without requests raise nothing
      wr(1, 8'hFE);
      expect_rd("R2", 1); expect_out("R4"); step();
      // R2/R8: single request 3
      wr(0, 8'h08);
      expect_rd("R2", 0); expect_out("R8"); step();
      // R3: written bit 0 reads back as 0
      wr(0, 8'h09);
      expect_rd("R3", 0); step();
      wr(1, 8'hFF);
      expect_rd("R3", 1); step();
      // R5: several requests, highest number wins
      wr(0, 8'hAA);
      expect_out("R5"); step();
      // R4: mask request 7 by its enable
      wr(1, 8'h2A);
      expect_out("R4"); step();
      // R6: execution level equal, then one below
      cur_prio = 4'd5; expect_out("R6"); step();
      cur_prio = 4'd4; expect_out("R6"); step();
      cur_prio = 4'd0;
      // R7: event tie, event below, event flag off with high priority
      evt_valid = 1'b1; evt_prio = 4'd5; expect_out("R7"); step();
      evt_prio = 4'd4; expect_out("R7"); step();
      evt_prio = 4'd9; expect_out("R7"); step();
      evt_valid = 1'b0; expect_out("R7"); step();
      // R9/R10: acknowledge keeps the request, taken follows one cycle later
      ack = 1'b1; expect_out("R9"); step();
      ack = 1'b0; push("R10", 5, 1); expect_out("R9"); expect_rd("R9", 0); step();
      push("R10", 5, 0); step();
      // R10: ack while irq is low gives no taken
      cur_prio = 4'd15; ack = 1'b1; expect_out("R10"); step();
      ack = 1'b0; push("R10", 5, 0); step();
      cur_prio = 4'd0;
      // R11: write cycle reads the old value, new value after the edge
      reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h02;
      push("R11", 4, sh_req); expect_out("R11"); step();
      reg_wr = 1'b0; sh_req = 8'h02;
      expect_rd("R11", 0); expect_out("R8"); step();
      // R6: request 1 at level 1 stays low
      cur_prio = 4'd1; expect_out("R6"); step();
      cur_prio = 4'd0;
      // R9: software clear removes the request
      wr(0, 8'h00);
      expect_out("R9"); expect_rd("R9", 0); step();
      step();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule